// File: doc/BRIEF.md
# Single-Context Interrupt Claim/Complete Controller

This block collects interrupt requests from up to `NSRC - 1` sources and presents them to one hart as a single interrupt line. Each source passes through a gateway that turns a level or an edge request into a pending bit. The gateway then holds the source off while software services it. Software programs a priority for each source, an enable bit for each source and one threshold, all through a plain 32-bit register bus. A register read returns data in the cycle after the read strobe. When no read is issued, the read data is 0.

The handler takes an interrupt by reading the claim/complete register. The read returns the identifier of the best eligible source and, on the same clock edge, clears that source's pending bit. When it is done, the handler writes the identifier back to the same register. That write releases the gateway, so the source may raise a new request. Word addresses use `bus_addr[21:2]`, and the two low address bits are ignored.

Source ID 0 does not exist. Its pending and enable bits read as 0, and its priority word is unmapped.

Top module: `irq_claim_ctrl`

## Requirements
- R1: Priority of source n (1 <= n < NSRC) is a word at byte offset 4*n. A write keeps only the low PRIO_W bits, and a read returns them zero-extended. Offset 0 reads 0.
- R2: Pending bits are read-only at 0x001000. Source n is bit n%32 of word n/32, bit 0 of word 0 always reads 0, and writes there change nothing.
- R3: Enable bits are at 0x002000 with the same packing as the pending bits. The enable bit for ID 0 always reads 0.
- R4: A read of 0x200004 returns the ID of the source that has the largest priority among sources that are pending, enabled and of non-zero priority. On equal priority the lower ID wins. The read returns 0 when no source qualifies, and the threshold never changes the result.
- R5: The claim read clears the returned source's pending bit on the same edge. The source cannot become pending again until a completion for it is accepted.
- R6: Writing ID k to 0x200004 releases source k whatever was claimed last. The write is dropped when k is 0, when k >= NSRC, or when k is not enabled.
- R7: A level source (EDGE_MASK bit 0) becomes pending one edge after its request is high while it is not held. A level source still high after its completion becomes pending again.
- R8: An edge source (EDGE_MASK bit 1) becomes pending on a rising edge of its request. A rising edge that arrives while the source is held is lost.
- R9: The threshold is at 0x200000 and is PRIO_W bits wide. irq_out is high exactly when the winner's priority is greater than the threshold.
- R10: Reads from unmapped offsets return 0, and writes to unmapped offsets change no state.
- R11: After reset all priorities, enables, pending bits, holds and the threshold are 0, and irq_out and bus_rdata are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | NSRC | Request lines, bit n for source n (bit 0 unused) |
| bus_addr | input | 22 | Byte address of the access |
| bus_re | input | 1 | Read strobe |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_re |
| irq_out | output | 1 | Interrupt line to the hart |

## Verification
The hardest state to reach is a held source whose gateway must stay closed. That covers a request still high, a repeated edge, or a completion that is refused because the source was disabled in the meantime. The directed part claims sources and then completes them out of order. It disables a source before completing it and pulses an edge source while that source is held. The random part reloads priorities, enables, threshold and request levels each round. It drains every claim until 0 comes back, which leaves stale pending bits on disabled sources for later rounds.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int ADDR_W = 22;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_PRIO,
    RG_PEND,
    RG_EN,
    RG_THR,
    RG_CLM
  } region_t;

  typedef struct packed {
    region_t    kind;
    logic [9:0] idx;
  } dec_t;

  // Map a byte address to a register region and word index.
  function automatic dec_t map_addr(input logic [ADDR_W-1:0] a,
                                    input int nsrc, input int nword);
    dec_t       d;
    logic [9:0] w;
    w      = a[11:2];
    d.kind = RG_NONE;
    d.idx  = '0;
    if (a[21:12] == 10'd0) begin
      if (w != 10'd0 && int'(w) < nsrc) begin
        d.kind = RG_PRIO;
        d.idx  = w;
      end
    end else if (a[21:12] == 10'd1) begin
      if (int'(w) < nword) begin
        d.kind = RG_PEND;
        d.idx  = w;
      end
    end else if (a[21:12] == 10'd2) begin
      if (int'(w) < nword) begin
        d.kind = RG_EN;
        d.idx  = w;
      end
    end else if (a[21:2] == 20'h80000) begin
      d.kind = RG_THR;
    end else if (a[21:2] == 20'h80001) begin
      d.kind = RG_CLM;
    end
    return d;
  endfunction

endpackage

// File: rtl/irqc_gateway.sv
module irqc_gateway #(
  parameter bit IS_EDGE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic claim,
  input  logic complete,
  output logic pend,
  output logic held
);

  logic prev_q, pend_q, held_q;
  logic trig;

  generate
    if (IS_EDGE) begin : g_edge
      assign trig = req & ~prev_q;
    end else begin : g_level
      assign trig = req;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
      held_q <= 1'b0;
    end else begin
      prev_q <= req;
      if (claim)
        pend_q <= 1'b0;
      else if (trig && !held_q)
        pend_q <= 1'b1;
      if (claim)
        held_q <= 1'b1;
      else if (complete)
        held_q <= 1'b0;
    end
  end

  assign pend = pend_q;
  assign held = held_q;

  // R5: a pending bit never rises while the source is held
  a_r5_no_repend_while_held: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> !$past(held_q));

  // R6: a hold only ends through an accepted completion
  a_r6_release_needs_complete: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(held_q) |-> $past(complete));

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
  parameter int NSRC   = 32,
  parameter int PRIO_W = 3,
  parameter int IDW    = 5
) (
  input  logic [NSRC-1:0]        elig,
  input  logic [NSRC*PRIO_W-1:0] prio_flat,
  output logic [IDW-1:0]         win_id,
  output logic [PRIO_W-1:0]      win_prio
);

  // Downward scan with >= so that the lowest ID wins a tie.
  function automatic logic [IDW+PRIO_W-1:0] pick(input logic [NSRC-1:0] e,
                                                 input logic [NSRC*PRIO_W-1:0] p);
    logic [PRIO_W-1:0] bp;
    logic [IDW-1:0]    bi;
    bp = '0;
    bi = '0;
    for (int i = NSRC - 1; i >= 1; i--) begin
      if (e[i] && p[i*PRIO_W +: PRIO_W] >= bp) begin
        bp = p[i*PRIO_W +: PRIO_W];
        bi = IDW'(i);
      end
    end
    return {bi, bp};
  endfunction

  always_comb begin
    {win_id, win_prio} = pick(elig, prio_flat);
  end

endmodule

// File: rtl/irq_claim_ctrl.sv
module irq_claim_ctrl
  import irqc_pkg::*;
#(
  parameter int              NSRC      = 32,
  parameter int              PRIO_W    = 3,
  parameter logic [NSRC-1:0] EDGE_MASK = NSRC'(32'hFF00_0000)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_req,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_re,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_out
);

  localparam int IDW   = (NSRC > 2) ? $clog2(NSRC) : 1;
  localparam int NWORD = (NSRC + 31) / 32;
  localparam int PADW  = NWORD * 32;

  dec_t                  dec;
  logic [PRIO_W-1:0]     prio_q [NSRC];
  logic [NSRC*PRIO_W-1:0] prio_flat;
  logic [NSRC-1:0]       en_q;
  logic [PRIO_W-1:0]     thr_q;
  logic [NSRC-1:0]       pend_vec, held_vec, elig;
  logic [PADW-1:0]       pend_pad, en_pad;
  logic [IDW-1:0]        win_id, cmp_id;
  logic [PRIO_W-1:0]     win_prio;
  logic                  claim_fire, cmp_fire;
  logic [31:0]           rd_mux;

  assign dec        = map_addr(bus_addr, NSRC, NWORD);
  assign claim_fire = bus_re && dec.kind == RG_CLM;
  assign cmp_id     = bus_wdata[IDW-1:0];
  assign cmp_fire   = bus_we && dec.kind == RG_CLM && bus_wdata != 32'd0 &&
                      bus_wdata < 32'(NSRC) && en_q[cmp_id];

  assign pend_vec[0] = 1'b0;
  assign held_vec[0] = 1'b0;
  assign elig[0]     = 1'b0;
  assign prio_flat[PRIO_W-1:0] = '0;

  generate
    for (genvar i = 1; i < NSRC; i++) begin : g_src
      irqc_gateway #(.IS_EDGE(EDGE_MASK[i])) u_gw (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (src_req[i]),
        .claim    (claim_fire && win_id == IDW'(i)),
        .complete (cmp_fire && cmp_id == IDW'(i)),
        .pend     (pend_vec[i]),
        .held     (held_vec[i])
      );
      assign prio_flat[i*PRIO_W +: PRIO_W] = prio_q[i];
      assign elig[i] = pend_vec[i] && en_q[i] && prio_q[i] != '0;
    end
  endgenerate

  irqc_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W), .IDW(IDW)) u_arb (
    .elig      (elig),
    .prio_flat (prio_flat),
    .win_id    (win_id),
    .win_prio  (win_prio)
  );

  assign pend_pad = PADW'(pend_vec);
  assign en_pad   = PADW'(en_q);

  always_comb begin
    rd_mux = 32'd0;
    case (dec.kind)
      RG_PRIO: rd_mux = 32'(prio_q[dec.idx[IDW-1:0]]);
      RG_PEND: rd_mux = pend_pad[32*int'(dec.idx) +: 32];
      RG_EN:   rd_mux = en_pad[32*int'(dec.idx) +: 32];
      RG_THR:  rd_mux = 32'(thr_q);
      RG_CLM:  rd_mux = 32'(win_id);
      default: rd_mux = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) prio_q[i] <= '0;
      en_q      <= '0;
      thr_q     <= '0;
      bus_rdata <= 32'd0;
    end else begin
      bus_rdata <= bus_re ? rd_mux : 32'd0;
      if (bus_we) begin
        case (dec.kind)
          RG_PRIO: prio_q[dec.idx[IDW-1:0]] <= bus_wdata[PRIO_W-1:0];
          RG_EN: begin
            for (int i = 1; i < NSRC; i++)
              if (i / 32 == int'(dec.idx)) en_q[i] <= bus_wdata[i % 32];
          end
          RG_THR:  thr_q <= bus_wdata[PRIO_W-1:0];
          default: ;
        endcase
      end
    end
  end

  assign irq_out = win_prio > thr_q;

  // R5: the claimed source is no longer pending after the claim edge
  a_r5_claim_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_fire && win_id != '0) |=> !pend_vec[$past(win_id)]);

  // R9: the line is only raised when some source qualifies
  a_r9_irq_has_winner: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (win_id != '0 && elig[win_id]));

  // R10: unmapped reads answer 0
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && dec.kind == RG_NONE) |=> bus_rdata == 32'd0);

  // R2: bit 0 of pending word 0 reads as 0
  a_r2_id0_pend_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && dec.kind == RG_PEND && dec.idx == 10'd0) |=> !bus_rdata[0]);

endmodule

// File: tb/irq_claim_ctrl_tb.sv
module irq_claim_ctrl_tb;

  localparam int NSRC = 32;
  localparam logic [21:0] A_PEND = 22'h001000;
  localparam logic [21:0] A_EN   = 22'h002000;
  localparam logic [21:0] A_THR  = 22'h200000;
  localparam logic [21:0] A_CLM  = 22'h200004;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_req = '0;
  logic [21:0] bus_addr = '0;
  logic        bus_re = 1'b0, bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;

  int n_chk = 0, n_bad = 0;

  int unsigned m_prio [NSRC];
  logic [31:0] m_en, m_pend, m_busy;

  always #5 clk = ~clk;

  irq_claim_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .bus_addr(bus_addr),
    .bus_re(bus_re), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    src_req = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_en = '0; m_pend = '0; m_busy = '0;
    for (int i = 0; i < NSRC; i++) m_prio[i] = 0;
  endtask

  task automatic wr(input logic [21:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [21:0] a, output logic [31:0] d);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  // Best qualifying source from the bench's own state; lowest ID on ties.
  function automatic int exp_claim();
    int best = 0, bp = 0;
    for (int i = 1; i < NSRC; i++)
      if (m_pend[i] && m_en[i] && m_prio[i] > bp) begin
        bp = m_prio[i];
        best = i;
      end
    return best;
  endfunction

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [31:0] v;
    int e;
    int unsigned thr;
    void'($urandom(32'd1234));
    do_reset();

    // R11 reset state
    chk(irq_out == 1'b0 && bus_rdata == 0, "R11 outputs after reset", {bus_rdata[30:0], irq_out}, 0);
    rd(A_THR, v);  chk(v == 0, "R11 threshold reset", v, 0);
    rd(A_PEND, v); chk(v == 0, "R11 pending reset", v, 0);
    rd(22'h00000C, v); chk(v == 0, "R11 priority reset", v, 0);

    // R1 priority width and offset 0
    wr(22'h00000C, 32'hFFFF_FFFD);
    rd(22'h00000C, v); chk(v == 32'd5, "R1 priority keeps low bits", v, 5);
    wr(22'h000000, 32'h7);
    rd(22'h000000, v); chk(v == 0, "R1 offset 0 reads 0", v, 0);

    // R10 unmapped offsets
    wr(22'h003000, 32'hFFFF_FFFF);
    rd(22'h003000, v); chk(v == 0, "R10 unmapped read", v, 0);
    wr(22'h200008, 32'h5);
    rd(A_THR, v); chk(v == 0, "R10 unmapped write leaves threshold", v, 0);

    // R3 enable packing, bit 0 hardwired
    wr(A_EN, 32'hFFFF_FFFF);
    rd(A_EN, v); chk(v == 32'hFFFF_FFFE, "R3 enable bit 0 zero", v, 32'hFFFF_FFFE);
    wr(A_EN, 32'h0);

    // R2 / R7 pending from a level source
    src_req[5] = 1'b1;
    @(negedge clk);
    rd(A_PEND, v); chk(v == 32'h20, "R7 level source pending", v, 32'h20);
    wr(A_PEND, 32'hFFFF_FFFF);
    rd(A_PEND, v); chk(v == 32'h20, "R2 pending write ignored", v, 32'h20);

    // R4 / R9 arbitration and threshold
    wr(22'h000014, 2); wr(22'h000024, 2); wr(22'h00001C, 6); wr(22'h00002C, 0);
    wr(A_EN, 32'h0000_0AA0);
    src_req[7] = 1'b1; src_req[9] = 1'b1; src_req[11] = 1'b1;
    @(negedge clk);
    wr(A_THR, 5);
    chk(irq_out == 1'b1, "R9 irq above threshold", irq_out, 1);
    wr(A_THR, 6);
    chk(irq_out == 1'b0, "R9 irq at threshold", irq_out, 0);
    rd(A_CLM, v); chk(v == 7, "R4 claim ignores threshold", v, 7);
    rd(A_CLM, v); chk(v == 5, "R4 tie to lower ID", v, 5);
    rd(A_CLM, v); chk(v == 9, "R4 next claim", v, 9);
    rd(A_CLM, v); chk(v == 0, "R4 zero priority not claimed", v, 0);
    rd(A_PEND, v); chk(v == 32'h800, "R5 claimed bits cleared while held", v, 32'h800);

    // R6 out-of-order completion, disabled completion dropped
    wr(A_CLM, 5);
    @(negedge clk);
    rd(A_PEND, v); chk(v == 32'h820, "R6 R7 completed level source pends again", v, 32'h820);
    wr(A_EN, 32'h0000_08A0);
    wr(A_CLM, 9);
    wr(A_EN, 32'h0000_0AA0);
    @(negedge clk);
    rd(A_PEND, v); chk(v == 32'h820, "R6 disabled completion ignored", v, 32'h820);
    wr(A_CLM, 40);
    wr(A_CLM, 9);
    @(negedge clk);
    rd(A_PEND, v); chk(v == 32'hA20, "R6 enabled completion accepted", v, 32'hA20);

    // R8 edge source
    wr(A_EN, 32'h0100_0000);
    wr(22'h000060, 4);
    src_req[24] = 1'b1; @(negedge clk); src_req[24] = 1'b0;
    rd(A_CLM, v); chk(v == 24, "R8 rising edge pends", v, 24);
    src_req[24] = 1'b1; @(negedge clk); src_req[24] = 1'b0;
    wr(A_CLM, 24);
    rd(A_CLM, v); chk(v == 0, "R8 edge while held lost", v, 0);
    src_req[24] = 1'b1; @(negedge clk);
    rd(A_CLM, v); chk(v == 24, "R8 new edge after completion", v, 24);
    @(negedge clk);
    src_req[24] = 1'b0;
    wr(A_CLM, 24);
    rd(A_CLM, v); chk(v == 0, "R8 held high gives no second edge", v, 0);

    // Random rounds on the level sources
    do_reset();
    for (int it = 0; it < 40; it++) begin
      logic [31:0] req;
      int bp;
      for (int i = 1; i < 24; i++) begin
        m_prio[i] = $urandom_range(0, 7);
        wr(22'(4 * i), 32'(m_prio[i]) | 32'hFFF0_0000);
      end
      m_en = $urandom() & 32'h00FF_FFFE;
      wr(A_EN, m_en);
      thr = $urandom_range(0, 7);
      wr(A_THR, thr);
      req = $urandom() & 32'h00FF_FFFE;
      src_req = req;
      @(negedge clk);
      m_pend = m_pend | (req & ~m_busy);
      e = exp_claim();
      bp = (e == 0) ? 0 : int'(m_prio[e]);
      chk(irq_out == (bp > int'(thr)), "R9 random irq", irq_out, bp > int'(thr));
      for (int k = 0; k < NSRC; k++) begin
        e = exp_claim();
        rd(A_CLM, v);
        chk(v == 32'(e), "R4 R5 random claim", v, e);
        if (e == 0) break;
        m_pend[e] = 1'b0;
        m_busy[e] = 1'b1;
      end
      src_req = '0;
      @(negedge clk);
      for (int i = 1; i < 24; i++)
        if (m_busy[i]) begin
          wr(A_CLM, i);
          m_busy[i] = 1'b0;
        end
      rd(A_PEND, v);
      chk(v == m_pend, "R2 random pending word", v, m_pend);
    end

    report();
  end

endmodule